// File: doc/BRIEF.md
# E3 G.832 Performance Monitor

This block watches the receive side of an E3 G.832 link one byte at a time. An upstream framer delivers each byte with a valid flag, a start-of-frame strobe and a tag that says which overhead byte it is, or that it is payload. From this stream the monitor keeps three error counts:

- frame-alignment errors, checked against the two fixed alignment bytes;
- parity errors, from a BIP-8 that covers every byte of a frame and is checked against the error-monitor byte of the frame that follows;
- far-end errors, reported in the maintenance byte.

For the alignment and parity counts, a mode input selects whether single bits or whole words/blocks are counted.

The monitor also derives the two status bits that the local transmitter places in its own maintenance byte. The defect-indication bit is raised from the local defect flags LOS, OOF, LOF and AIS, through a per-defect enable mask. The error-indication bit pulses for each received frame that carried a parity error. All three counters saturate. They are read through one latch strobe, which copies every counter to a holding register and restarts the count.

Top module: `e3_perf_mon`

## Requirements
- R1: The BIP-8 of a frame is the XOR of every valid byte from its start-of-frame byte up to the byte before the next start-of-frame. It is compared only with the error-monitor byte (tag 3) of the next frame. The first frame after reset yields no comparison.
- R2: With bip_bit_mode=1, the parity count rises by the number of bits that differ between the error-monitor byte and the reference BIP-8 (0 to 8 per frame).
- R3: With bip_bit_mode=0, the parity count rises by 1 for a frame whose error-monitor byte differs in any bit, and by 0 otherwise.
- R4: With fa_bit_mode=1, the alignment count rises by the number of bits in which a tag 1 byte differs from 0xF6, plus the number of bits in which a tag 2 byte differs from 0x28.
- R5: With fa_bit_mode=0, the alignment count rises by exactly 1 per frame, at the tag 2 byte, when either alignment byte is wrong, and by 0 when both are right.
- R6: The far-end count rises by 1 for each maintenance byte (tag 5) whose bit 6 is 1. Bit 6 of bytes with any other tag, including payload (tag 0), has no effect.
- R7: tx_rdi equals, one clock later, the OR of {ais,lof,oof,los} & rdi_en. Here rdi_en[0] gates LOS, [1] gates OOF, [2] gates LOF and [3] gates AIS.
- R8: tx_rei is high for exactly the one cycle that follows an error-monitor byte which produced a parity error, and is low at every other time.
- R9: Each 16-bit counter stops at 65535 and never wraps.
- R10: When cnt_latch is high, each holding output takes its counter value plus that cycle's increment (saturated), and the counter restarts from 0. When cnt_latch is low, the holding outputs do not change.
- R11: After reset, all holding outputs, tx_rdi and tx_rei are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Byte on rx_data is valid this cycle |
| rx_sof | input | 1 | First byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Received byte |
| rx_tag | input | 3 | 0 payload, 1 FA1, 2 FA2, 3 error monitor, 4 trail trace, 5 maintenance, 6 network, 7 general |
| los | input | 1 | Loss of signal |
| oof | input | 1 | Out of frame |
| lof | input | 1 | Loss of frame |
| ais | input | 1 | Alarm indication signal |
| rdi_en | input | 4 | Per-defect enables for tx_rdi |
| fa_bit_mode | input | 1 | 1: count alignment bits, 0: count bad alignment words |
| bip_bit_mode | input | 1 | 1: count parity bits, 0: count bad blocks |
| cnt_latch | input | 1 | Copy counters to the holding outputs and restart them |
| fa_err_hold | output | 16 | Latched alignment error count |
| bip_err_hold | output | 16 | Latched parity error count |
| rei_err_hold | output | 16 | Latched far-end error count |
| tx_rdi | output | 1 | Defect-indication bit for the transmit maintenance byte |
| tx_rei | output | 1 | Error-indication pulse for the transmit maintenance byte |

## Verification
The assertions watch four things on every cycle:

- the registered defect mask behind tx_rdi;
- that a tx_rei pulse only ever follows an error-monitor byte;
- that a full counter does not wrap;
- that the holding outputs move only on a latch, with the live counts cleared just after it.

The bench scenarios are the only place where the counted values themselves are shown. These are the bit and word/block tallies against hand-chosen corruptions, the one-frame delay of the parity reference and the silent first frame, the fact that bit 6 of payload bytes does not count, and an increment that lands in the same cycle as a latch being kept.

// File: rtl/e3pm_pkg.sv
package e3pm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    TAG_PAYLOAD = 3'd0,
    TAG_FA1     = 3'd1,
    TAG_FA2     = 3'd2,
    TAG_EM      = 3'd3,
    TAG_TR      = 3'd4,
    TAG_MA      = 3'd5,
    TAG_NR      = 3'd6,
    TAG_GC      = 3'd7
  } oh_tag_e;

  localparam logic [BYTE_W-1:0] FA1_PATTERN = 8'hF6;
  localparam logic [BYTE_W-1:0] FA2_PATTERN = 8'h28;
  localparam int MA_REI_BIT = 6;

  // number of set bits in a byte, 0..8
  function automatic logic [3:0] ones8(input logic [BYTE_W-1:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/e3pm_bip_check.sv
module e3pm_bip_check
  import e3pm_pkg::*;
#(
  parameter int INC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              sof,
  input  logic [BYTE_W-1:0] data,
  input  logic              is_em,
  input  logic              bit_mode,
  output logic [INC_W-1:0]  inc,
  output logic              frame_err
);
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic [BYTE_W-1:0] ref_q, ref_d;
  logic              ref_ok_q, ref_ok_d;
  logic              seen_q, seen_d;
  logic [BYTE_W-1:0] diff;
  logic              cmp_en;

  // next state: running parity, reference from the previous frame
  always_comb begin
    acc_d    = acc_q;
    ref_d    = ref_q;
    ref_ok_d = ref_ok_q;
    seen_d   = seen_q;
    if (valid) begin
      if (sof) begin
        acc_d    = data;
        ref_d    = acc_q;
        ref_ok_d = seen_q;
        seen_d   = 1'b1;
      end else begin
        acc_d = acc_q ^ data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      ref_q    <= '0;
      ref_ok_q <= 1'b0;
      seen_q   <= 1'b0;
    end else if (valid) begin
      acc_q    <= acc_d;
      ref_q    <= ref_d;
      ref_ok_q <= ref_ok_d;
      seen_q   <= seen_d;
    end
  end

  assign diff      = data ^ ref_q;
  assign cmp_en    = valid && is_em && ref_ok_q;
  assign frame_err = cmp_en && (|diff);

  always_comb begin
    inc = '0;
    if (cmp_en) begin
      if (bit_mode) inc = INC_W'(ones8(diff));
      else          inc = INC_W'(|diff);
    end
  end
endmodule

// File: rtl/e3pm_fa_check.sv
module e3pm_fa_check
  import e3pm_pkg::*;
#(
  parameter int INC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              is_fa1,
  input  logic              is_fa2,
  input  logic [BYTE_W-1:0] data,
  input  logic              bit_mode,
  output logic [INC_W-1:0]  inc
);
  logic              fa1_bad_q, fa1_bad_d;
  logic              fa1_en;
  logic [BYTE_W-1:0] mis1, mis2;

  assign mis1   = data ^ FA1_PATTERN;
  assign mis2   = data ^ FA2_PATTERN;
  assign fa1_en = valid && is_fa1;

  always_comb begin
    fa1_bad_d = |mis1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fa1_bad_q <= 1'b0;
    else if (fa1_en) fa1_bad_q <= fa1_bad_d;
  end

  always_comb begin
    inc = '0;
    if (valid) begin
      if (bit_mode) begin
        if (is_fa1)      inc = INC_W'(ones8(mis1));
        else if (is_fa2) inc = INC_W'(ones8(mis2));
      end else if (is_fa2) begin
        inc = INC_W'(fa1_bad_q || (|mis2));
      end
    end
  end
endmodule

// File: rtl/e3pm_sat_counter.sv
module e3pm_sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             latch,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] sat;

  assign sum = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
  assign sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_comb begin
    cnt_d  = latch ? '0 : sat;
    hold_d = latch ? sat : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (latch) hold_q <= hold_d;
  end

  assign live = cnt_q;
  assign hold = hold_q;
endmodule

// File: rtl/e3_perf_mon.sv
module e3_perf_mon
  import e3pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  input  logic [2:0]       rx_tag,
  input  logic             los,
  input  logic             oof,
  input  logic             lof,
  input  logic             ais,
  input  logic [3:0]       rdi_en,
  input  logic             fa_bit_mode,
  input  logic             bip_bit_mode,
  input  logic             cnt_latch,
  output logic [CNT_W-1:0] fa_err_hold,
  output logic [CNT_W-1:0] bip_err_hold,
  output logic [CNT_W-1:0] rei_err_hold,
  output logic             tx_rdi,
  output logic             tx_rei
);
  localparam int NUM_CNT = 3;
  localparam int INC_W   = 4;
  localparam int IDX_FA  = 0;
  localparam int IDX_BIP = 1;
  localparam int IDX_REI = 2;

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic is_fa1, is_fa2, is_em, is_ma;
  assign is_fa1 = (rx_tag == TAG_FA1);
  assign is_fa2 = (rx_tag == TAG_FA2);
  assign is_em  = (rx_tag == TAG_EM);
  assign is_ma  = (rx_tag == TAG_MA);

  logic [NUM_CNT-1:0][INC_W-1:0] inc_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_live;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_hold;
  logic                          bip_frame_err;

  e3pm_fa_check #(.INC_W(INC_W)) u_fa (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid    (rx_valid),
    .is_fa1   (is_fa1),
    .is_fa2   (is_fa2),
    .data     (rx_data),
    .bit_mode (fa_bit_mode),
    .inc      (inc_vec[IDX_FA])
  );

  e3pm_bip_check #(.INC_W(INC_W)) u_bip (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid     (rx_valid),
    .sof       (rx_sof),
    .data      (rx_data),
    .is_em     (is_em),
    .bit_mode  (bip_bit_mode),
    .inc       (inc_vec[IDX_BIP]),
    .frame_err (bip_frame_err)
  );

  assign inc_vec[IDX_REI] = INC_W'(rx_valid && is_ma && rx_data[MA_REI_BIT]);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    e3pm_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (inc_vec[g]),
      .latch (cnt_latch),
      .live  (cnt_live[g]),
      .hold  (cnt_hold[g])
    );
  end

  assign fa_err_hold  = cnt_hold[IDX_FA];
  assign bip_err_hold = cnt_hold[IDX_BIP];
  assign rei_err_hold = cnt_hold[IDX_REI];

  logic [3:0] defect_vec;
  logic       rdi_d, rei_d;
  logic       rdi_q, rei_q;
  assign defect_vec = {ais, lof, oof, los};

  always_comb begin
    rdi_d = |(defect_vec & rdi_en);
    rei_d = bip_frame_err;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdi_q <= 1'b0;
      rei_q <= 1'b0;
    end else begin
      rdi_q <= rdi_d;
      rei_q <= rei_d;
    end
  end

  assign tx_rdi = rdi_q;
  assign tx_rei = rei_q;
endmodule

// File: rtl/e3pm_checker.sv
module e3pm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             rx_valid,
  input logic [2:0]       rx_tag,
  input logic [3:0]       defects,
  input logic [3:0]       rdi_en,
  input logic             cnt_latch,
  input logic             tx_rdi,
  input logic             tx_rei,
  input logic [CNT_W-1:0] fa_live,
  input logic [CNT_W-1:0] bip_live,
  input logic [CNT_W-1:0] rei_live,
  input logic [CNT_W-1:0] fa_hold,
  input logic [CNT_W-1:0] bip_hold,
  input logic [CNT_W-1:0] rei_hold
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_rdi_mask_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (tx_rdi == $past(|(defects & rdi_en))));

  assert_rei_after_em_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_rei |-> $past(rx_valid && (rx_tag == 3'd3)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fa_live == TOP && !cnt_latch) |=> (fa_live == TOP));

  assert_bip_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bip_live == TOP && !cnt_latch) |=> (bip_live == TOP));

  assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_latch |=> ($stable(fa_hold) && $stable(bip_hold) && $stable(rei_hold)));

  assert_clear_on_latch_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_latch |=> (fa_live == '0 && bip_live == '0 && rei_live == '0));

  assert_rei_step_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cnt_latch && rei_live != TOP) |=>
      ((rei_live == $past(rei_live)) || (rei_live == $past(rei_live) + 1'b1)));
endmodule

bind e3_perf_mon e3pm_checker #(.CNT_W(CNT_W)) u_e3pm_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rx_valid   (rx_valid),
  .rx_tag     (rx_tag),
  .defects    ({ais, lof, oof, los}),
  .rdi_en     (rdi_en),
  .cnt_latch  (cnt_latch),
  .tx_rdi     (tx_rdi),
  .tx_rei     (tx_rei),
  .fa_live    (cnt_live[0]),
  .bip_live   (cnt_live[1]),
  .rei_live   (cnt_live[2]),
  .fa_hold    (fa_err_hold),
  .bip_hold   (bip_err_hold),
  .rei_hold   (rei_err_hold)
);

// File: tb/e3_perf_mon_tb.sv
module e3_perf_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 65535;

  logic        clk;
  logic        rst_n;
  logic        rx_valid, rx_sof, cnt_latch;
  logic [7:0]  rx_data;
  logic [2:0]  rx_tag;
  logic        los, oof, lof, ais;
  logic [3:0]  rdi_en;
  logic        fa_bit_mode, bip_bit_mode;
  logic [15:0] fa_err_hold, bip_err_hold, rei_err_hold;
  logic        tx_rdi, tx_rei;

  e3_perf_mon dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .rx_tag(rx_tag), .los(los), .oof(oof), .lof(lof),
    .ais(ais), .rdi_en(rdi_en), .fa_bit_mode(fa_bit_mode),
    .bip_bit_mode(bip_bit_mode), .cnt_latch(cnt_latch),
    .fa_err_hold(fa_err_hold), .bip_err_hold(bip_err_hold),
    .rei_err_hold(rei_err_hold), .tx_rdi(tx_rdi), .tx_rei(tx_rei)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    int    fa;
    int    bip;
    int    rei;
    string req;
  } exp_item_t;
  exp_item_t sb_q[$];

  // reference model state
  logic [7:0] m_acc = 8'h00, m_ref = 8'h00;
  bit         m_ref_ok = 0, m_seen = 0, m_fa1_bad = 0;
  int         m_fa = 0, m_bip = 0, m_rei = 0;
  bit         exp_rei_next = 0;
  string      cur_req = "R10";

  function automatic int sat_add(input int a, input int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic book(input int fi, input int bi, input int ri, input bit lt);
    exp_item_t it;
    if (lt) begin
      it.fa = sat_add(m_fa, fi); it.bip = sat_add(m_bip, bi);
      it.rei = sat_add(m_rei, ri); it.req = cur_req;
      sb_q.push_back(it);
      m_fa = 0; m_bip = 0; m_rei = 0;
    end else begin
      m_fa = sat_add(m_fa, fi); m_bip = sat_add(m_bip, bi); m_rei = sat_add(m_rei, ri);
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input logic [2:0] t, input bit s, input bit lt);
    int fi, bi, ri;
    @(negedge clk);
    check(tx_rei == exp_rei_next, "R8", tx_rei, exp_rei_next);
    rx_valid = 1'b1; rx_data = d; rx_tag = t; rx_sof = s; cnt_latch = lt;
    fi = 0; bi = 0; ri = 0;
    if (t == 3'd3 && m_ref_ok)
      bi = bip_bit_mode ? $countones(d ^ m_ref) : int'((d ^ m_ref) != 8'h00);
    if (s) begin m_ref = m_acc; m_ref_ok = m_seen; m_seen = 1; m_acc = d; end
    else m_acc = m_acc ^ d;
    if (t == 3'd1) begin
      m_fa1_bad = (d != 8'hF6);
      if (fa_bit_mode) fi = $countones(d ^ 8'hF6);
    end else if (t == 3'd2) begin
      fi = fa_bit_mode ? $countones(d ^ 8'h28) : int'(m_fa1_bad || d != 8'h28);
    end
    if (t == 3'd5 && d[6]) ri = 1;
    exp_rei_next = (bi > 0);
    book(fi, bi, ri, lt);
  endtask

  task automatic idle(input bit lt);
    @(negedge clk);
    check(tx_rei == exp_rei_next, "R8", tx_rei, exp_rei_next);
    rx_valid = 1'b0; rx_sof = 1'b0; cnt_latch = lt; rx_tag = 3'd0;
    exp_rei_next = 0;
    book(0, 0, 0, lt);
  endtask

  // 16-byte frame: 7 overhead bytes then 9 payload bytes
  task automatic send_frame(input logic [7:0] fa1, input logic [7:0] fa2,
                            input logic [7:0] em_mask, input logic [7:0] ma,
                            input int latch_at, input logic [7:0] seed);
    put_byte(fa1, 3'd1, 1'b1, latch_at == 0);
    put_byte(fa2, 3'd2, 1'b0, latch_at == 1);
    put_byte(m_ref ^ em_mask, 3'd3, 1'b0, latch_at == 2);
    put_byte(seed, 3'd4, 1'b0, latch_at == 3);
    put_byte(ma, 3'd5, 1'b0, latch_at == 4);
    put_byte(seed ^ 8'h5A, 3'd6, 1'b0, latch_at == 5);
    put_byte(seed + 8'd3, 3'd7, 1'b0, latch_at == 6);
    for (int i = 7; i < 16; i++)
      put_byte(8'h40 | (seed + 8'(i * 7)), 3'd0, 1'b0, latch_at == i);
  endtask

  task automatic latch_now(input string req);
    cur_req = req;
    idle(1'b1);
    idle(1'b0);
    idle(1'b0);
  endtask

  task automatic rdi_case(input logic [3:0] dv, input logic [3:0] en);
    int exp;
    @(negedge clk);
    {ais, lof, oof, los} = dv; rdi_en = en;
    exp = int'(|(dv & en));
    @(negedge clk);
    check(tx_rdi == exp[0], "R7", tx_rdi, exp);
  endtask

  // scoreboard monitor: pop one expected item per latch
  initial begin
    forever begin
      @(posedge clk);
      if (cnt_latch === 1'b1) begin
        exp_item_t it;
        #1;
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", 0, 1);
        end else begin
          it = sb_q.pop_front();
          check(fa_err_hold == 16'(it.fa), it.req, fa_err_hold, it.fa);
          check(bip_err_hold == 16'(it.bip), it.req, bip_err_hold, it.bip);
          check(rei_err_hold == 16'(it.rei), it.req, rei_err_hold, it.rei);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; cnt_latch = 1'b0;
    rx_data = 8'h00; rx_tag = 3'd0; los = 0; oof = 0; lof = 0; ais = 0;
    rdi_en = 4'h0; fa_bit_mode = 1'b1; bip_bit_mode = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(fa_err_hold == 0 && bip_err_hold == 0 && rei_err_hold == 0, "R11", fa_err_hold | bip_err_hold | rei_err_hold, 0);
    check(tx_rdi == 0 && tx_rei == 0, "R11", {tx_rdi, tx_rei}, 0);

    // R1: first frame gives no parity comparison even with a wild EM byte
    send_frame(8'hF6, 8'h28, 8'hA5, 8'h00, -1, 8'h11);
    latch_now("R1");
    // R1: correct EM in the next frame gives zero
    send_frame(8'hF6, 8'h28, 8'h00, 8'h00, -1, 8'h23);
    latch_now("R1");

    // R2: bit mode, four differing bits
    send_frame(8'hF6, 8'h28, 8'hB1, 8'h00, -1, 8'h37);
    send_frame(8'hF6, 8'h28, 8'h00, 8'h00, -1, 8'h48);
    latch_now("R2");

    // R3: block mode, one per bad frame however many bits
    bip_bit_mode = 1'b0;
    send_frame(8'hF6, 8'h28, 8'hFF, 8'h00, -1, 8'h52);
    send_frame(8'hF6, 8'h28, 8'h01, 8'h00, -1, 8'h61);
    send_frame(8'hF6, 8'h28, 8'h00, 8'h00, -1, 8'h70);
    latch_now("R3");
    bip_bit_mode = 1'b1;

    // R4: alignment bit mode
    send_frame(8'hF6 ^ 8'h03, 8'h28 ^ 8'h80, 8'h00, 8'h00, -1, 8'h05);
    latch_now("R4");

    // R5: alignment word mode
    fa_bit_mode = 1'b0;
    send_frame(8'h00, 8'hFF, 8'h00, 8'h00, -1, 8'h0C);
    send_frame(8'hF6, 8'h29, 8'h00, 8'h00, -1, 8'h1D);
    send_frame(8'hF7, 8'h28, 8'h00, 8'h00, -1, 8'h2E);
    send_frame(8'hF6, 8'h28, 8'h00, 8'h00, -1, 8'h3F);
    latch_now("R5");
    fa_bit_mode = 1'b1;

    // R6: far-end count from bit 6 of the maintenance byte only
    send_frame(8'hF6, 8'h28, 8'h00, 8'h40, -1, 8'h41);
    send_frame(8'hF6, 8'h28, 8'h00, 8'hFF, -1, 8'h42);
    send_frame(8'hF6, 8'h28, 8'h00, 8'h80, -1, 8'h43);
    send_frame(8'hF6, 8'h28, 8'h00, 8'h40, -1, 8'h44);
    latch_now("R6");

    // R7: defect mask
    rdi_case(4'b0001, 4'b0001);
    rdi_case(4'b0001, 4'b1110);
    rdi_case(4'b0010, 4'b0010);
    rdi_case(4'b0100, 4'b0100);
    rdi_case(4'b1000, 4'b1000);
    rdi_case(4'b1000, 4'b0111);
    rdi_case(4'b1111, 4'b0000);
    rdi_case(4'b0000, 4'b1111);

    // R10: latch on a byte that also increments keeps that increment
    send_frame(8'h09, 8'hD7, 8'h00, 8'h00, 0, 8'h66);
    latch_now("R10");

    // R9: saturation with 16 alignment bit errors per frame
    for (int f = 0; f < 4100; f++)
      send_frame(8'h09, 8'hD7, 8'h00, 8'h00, -1, 8'(f));
    latch_now("R9");

    idle(1'b0);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule